// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the 11-bit instruction address of a small controller whose program store holds up to 2K words. The store is split into 512-word pages. Each time the core finishes an instruction, the core raises a step strobe. The unit then moves the address forward by one, or loads a new address.

A new address can come from four sources:
- a jump, which takes a 9-bit immediate;
- a subroutine call, which takes an 8-bit immediate and saves the return address;
- a return, which restores the saved address;
- an instruction that writes the W value to the counter, or adds W to it, as if the counter were a data register.

Two page bits from the status register supply the upper address bits for every load except a return. A call, a counter write and a counter add all force address bit 8 to zero. Targets reached these ways can therefore only lie in the lower half of a page. Return addresses sit in a two-entry stack. The entry on top of that stack is an output of the block.

Top module: `paged_pc`

## Requirements
- R1: While rst_ni is low, pc_o is 0x7FF and the stack entries are zero, so stack_top_o is 0. The first increment after reset wraps the address to 0x000.
- R2: A cycle with step_i low leaves pc_o and stack_top_o unchanged, whatever the other strobes hold.
- R3: A step with no strobe raised loads pc_o+1 modulo 2048 into the counter on the next clock edge.
- R4: A step with jump_i high loads {page_i, imm_i[8:0]}, where page_i[1] is the high address bit (bit 10).
- R5: A step with call_i high loads {page_i, 1'b0, imm_i[7:0]}, so bit 8 of the new address is 0.
- R6: A call pushes pc_o+1 (modulo 2048) onto the stack, so stack_top_o shows that value next. The previous top entry moves to the second entry.
- R7: A step with ret_i high loads the top stack entry into the counter. The second entry moves to the top, and the second entry keeps its value, so a repeated return sees the same address again.
- R8: A step with pc_wr_i high loads {page_i, 1'b0, w_i}.
- R9: A step with pc_add_i high loads {page_i, 1'b0, (pc_o + 1 + w_i) mod 256}.
- R10: When several strobes are high together, jump_i wins over call_i, call_i over ret_i, ret_i over pc_wr_i, and pc_wr_i over pc_add_i. Only the winning strobe has any effect, including on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Instruction completes this cycle |
| jump_i | input | 1 | Jump load |
| call_i | input | 1 | Call load with push |
| ret_i | input | 1 | Return with pop |
| pc_wr_i | input | 1 | W written to the counter |
| pc_add_i | input | 1 | W added to the counter |
| imm_i | input | 9 | Immediate address field |
| w_i | input | 8 | W register value |
| page_i | input | 2 | Page-select bits |
| pc_o | output | 11 | Current program counter |
| stack_top_o | output | 11 | Top return-stack entry |

## Verification
The assertions check on every cycle the following:
- the hold when no step is given;
- the plain increment with wrap;
- the jump and call targets;
- the return load, and the value pushed by a call.

Only the bench scenarios can show the following:
- the second stack entry and its duplication after two returns;
- the add arithmetic across a low-byte overflow;
- which source wins when several strobes are high together.

The bench compares every cycle against a reference model of the counter and the two-entry stack.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;
  localparam int PC_W    = 11;
  localparam int JMP_W   = 9;
  localparam int DEPTH   = 2;
  localparam int LOW_W   = JMP_W - 1;
  localparam int PAGE_W  = PC_W - JMP_W;

  typedef enum logic [2:0] {
    SRC_HOLD, SRC_INC, SRC_JMP, SRC_CALL, SRC_RET, SRC_WR, SRC_ADD
  } pc_src_e;
endpackage

// File: rtl/paged_pc_src.sv
module paged_pc_src
  import paged_pc_pkg::*;
(
  input  logic step_i,
  input  logic jump_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic pc_wr_i,
  input  logic pc_add_i,
  output pc_src_e src_o
);
  // fixed priority: jump > call > ret > write > add > increment
  always_comb begin
    if (!step_i)        src_o = SRC_HOLD;
    else if (jump_i)    src_o = SRC_JMP;
    else if (call_i)    src_o = SRC_CALL;
    else if (ret_i)     src_o = SRC_RET;
    else if (pc_wr_i)   src_o = SRC_WR;
    else if (pc_add_i)  src_o = SRC_ADD;
    else                src_o = SRC_INC;
  end
endmodule

// File: rtl/paged_pc_target.sv
module paged_pc_target
  import paged_pc_pkg::*;
(
  input  pc_src_e           src_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   top_i,
  input  logic [JMP_W-1:0]  imm_i,
  input  logic [LOW_W-1:0]  w_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PC_W-1:0]   pc_nxt_o,
  output logic [PC_W-1:0]   ret_addr_o
);
  logic [PC_W-1:0]  pc_inc;
  logic [LOW_W-1:0] add_low;

  assign pc_inc     = pc_i + PC_W'(1);
  assign add_low    = pc_inc[LOW_W-1:0] + w_i;
  assign ret_addr_o = pc_inc;

  always_comb begin
    unique case (src_i)
      SRC_HOLD: pc_nxt_o = pc_i;
      SRC_JMP:  pc_nxt_o = {page_i, imm_i};
      SRC_CALL: pc_nxt_o = {page_i, 1'b0, imm_i[LOW_W-1:0]};
      SRC_RET:  pc_nxt_o = top_i;
      SRC_WR:   pc_nxt_o = {page_i, 1'b0, w_i};
      SRC_ADD:  pc_nxt_o = {page_i, 1'b0, add_low};
      default:  pc_nxt_o = pc_inc;
    endcase
  end
endmodule

// File: rtl/paged_pc_stack.sv
module paged_pc_stack
  import paged_pc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] data_i,
  output logic [PC_W-1:0] top_o
);
  logic [PC_W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [PC_W-1:0] below, above;
    if (i == 0) begin : g_first
      assign below = data_i;
    end else begin : g_rest
      assign below = ent[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign above = ent[i];       // bottom duplicates on pop
    end else begin : g_mid
      assign above = ent[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent[i] <= '0;
      else if (push_i) ent[i] <= below;
      else if (pop_i)  ent[i] <= above;
    end
  end

  assign top_o = ent[0];

  // R6: pushed value appears on top
  a_r6_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(data_i));
  a_r6_no_push_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import paged_pc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              pc_wr_i,
  input  logic              pc_add_i,
  input  logic [8:0]        imm_i,
  input  logic [7:0]        w_i,
  input  logic [1:0]        page_i,
  output logic [10:0]       pc_o,
  output logic [10:0]       stack_top_o
);
  pc_src_e         src;
  logic [PC_W-1:0] pc_q, pc_nxt, ret_addr, top;

  paged_pc_src u_src (
    .step_i, .jump_i, .call_i, .ret_i, .pc_wr_i, .pc_add_i, .src_o(src)
  );

  paged_pc_target u_tgt (
    .src_i(src), .pc_i(pc_q), .top_i(top), .imm_i(imm_i), .w_i(w_i),
    .page_i(page_i), .pc_nxt_o(pc_nxt), .ret_addr_o(ret_addr)
  );

  paged_pc_stack u_stk (
    .clk_i, .rst_ni,
    .push_i(src == SRC_CALL), .pop_i(src == SRC_RET),
    .data_i(ret_addr), .top_o(top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '1;
    else         pc_q <= pc_nxt;
  end

  assign pc_o        = pc_q;
  assign stack_top_o = top;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o) && $stable(stack_top_o));
  a_r3_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !(jump_i || call_i || ret_i || pc_wr_i || pc_add_i)
    |=> pc_o == PC_W'($past(pc_o) + 11'd1));
  a_r4_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && jump_i |=> pc_o == {$past(page_i), $past(imm_i)});
  a_r5_call_bit8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && call_i && !jump_i |=> !pc_o[8] && pc_o[10:9] == $past(page_i));
  a_r6_call_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && call_i && !jump_i |=> stack_top_o == PC_W'($past(pc_o) + 11'd1));
  a_r7_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && ret_i && !jump_i && !call_i |=> pc_o == $past(stack_top_o));
endmodule

// File: tb/paged_pc_bench.sv
module paged_pc_bench;
  logic clk = 0, rst_n = 0;
  logic step, jmp, cal, ret, wr, add;
  logic [8:0] imm;
  logic [7:0] w;
  logic [1:0] page;
  logic [10:0] pc, top;
  int checks = 0, fails = 0;
  logic [10:0] m_pc, m_s0, m_s1;
  bit done = 0;

  always #10 clk = ~clk;

  paged_pc u_paged_pc (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .jump_i(jmp), .call_i(cal),
    .ret_i(ret), .pc_wr_i(wr), .pc_add_i(add), .imm_i(imm), .w_i(w),
    .page_i(page), .pc_o(pc), .stack_top_o(top)
  );

  task automatic chk(string req, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of();
    if (!step) return "R2";
    if (jmp) return (cal | ret | wr | add) ? "R10" : "R4";
    if (cal) return (ret | wr | add) ? "R10" : "R5/R6";
    if (ret) return (wr | add) ? "R10" : "R7";
    if (wr) return add ? "R10" : "R8";
    if (add) return "R9";
    return "R3";
  endfunction

  // reference model, applied once per step
  task automatic model();
    logic [10:0] inc;
    inc = m_pc + 11'd1;
    if (!step) return;
    if (jmp) m_pc = {page, imm};
    else if (cal) begin
      m_s1 = m_s0; m_s0 = inc; m_pc = {page, 1'b0, imm[7:0]};
    end else if (ret) begin
      m_pc = m_s0; m_s0 = m_s1;
    end else if (wr) m_pc = {page, 1'b0, w};
    else if (add) m_pc = {page, 1'b0, 8'(inc[7:0] + w)};
    else m_pc = inc;
  endtask

  task automatic apply(logic s, logic j, logic c, logic r, logic wv, logic a,
                       logic [8:0] im, logic [7:0] wd, logic [1:0] pg);
    string t;
    step = s; jmp = j; cal = c; ret = r; wr = wv; add = a;
    imm = im; w = wd; page = pg;
    t = tag_of();
    model();
    @(negedge clk);
    chk({t, " pc"}, pc, m_pc);
    chk({t, " top"}, top, m_s0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    {step, jmp, cal, ret, wr, add} = '0; imm = '0; w = '0; page = '0;
    m_pc = 11'h7FF; m_s0 = '0; m_s1 = '0;
    repeat (2) @(negedge clk);
    chk("R1 reset pc", pc, 11'h7FF);
    chk("R1 reset top", top, 11'h000);
    rst_n = 1;
    @(negedge clk);
    // R1: first step wraps to 0
    apply(1,0,0,0,0,0, 9'h0, 8'h0, 2'd0);
    chk("R1 wrap", pc, 11'h000);
    // R2: strobes ignored without step
    apply(0,1,1,1,1,1, 9'h1AB, 8'h55, 2'd3);
    // R4 jump to top of page 3, then R3 wrap across page boundary
    apply(1,1,0,0,0,0, 9'h1FF, 8'h00, 2'd3);
    chk("R4 jump", pc, 11'h7FF);
    apply(1,0,0,0,0,0, 9'h0, 8'h0, 2'd0);
    chk("R3 wrap", pc, 11'h000);
    // R5/R6 nested calls, R7 double return duplicates bottom
    apply(1,0,1,0,0,0, 9'h1F0, 8'h0, 2'd2);
    chk("R5 bit8 clear", pc, 11'h4F0);
    apply(1,0,1,0,0,0, 9'h022, 8'h0, 2'd1);
    chk("R6 push", top, 11'h4F1);
    apply(1,0,0,1,0,0, 9'h0, 8'h0, 2'd0);
    chk("R7 pop1", pc, 11'h4F1);
    apply(1,0,0,1,0,0, 9'h0, 8'h0, 2'd0);
    apply(1,0,0,1,0,0, 9'h0, 8'h0, 2'd0);
    chk("R7 dup", pc, 11'h001);
    // R8 write, R9 add with low-byte overflow
    apply(1,0,0,0,1,0, 9'h0, 8'hC3, 2'd1);
    chk("R8 write", pc, 11'h2C3);
    apply(1,0,0,0,0,1, 9'h0, 8'h50, 2'd2);
    chk("R9 add wrap", pc, 11'h414);
    // R10 priority corners
    apply(1,0,1,1,1,1, 9'h033, 8'h77, 2'd0);
    apply(1,0,0,1,1,1, 9'h0, 8'h77, 2'd0);
    apply(1,0,0,0,1,1, 9'h0, 8'h12, 2'd3);
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [5:0] st;
      k = $urandom_range(0, 9);
      case (k)
        0: st = 6'b000000;
        1: st = 6'b100000;
        2: st = 6'b110000;
        3: st = 6'b101000;
        4, 5: st = 6'b100100;
        6: st = 6'b100010;
        7: st = 6'b100001;
        8: st = {1'b1, 5'($urandom)};
        default: st = {1'b0, 5'($urandom)};
      endcase
      apply(st[5], st[4], st[3], st[2], st[1], st[0],
            9'($urandom), 8'($urandom), 2'($urandom));
    end
    // R1 asynchronous reset mid-run
    #5 rst_n = 0;
    #2;
    chk("R1 async reset", pc, 11'h7FF);
    chk("R1 async top", top, 11'h000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule